// File: doc/BRIEF.md
# Transition Timestamp Event Recorder

This block watches a bank of asynchronous digital input channels, such as optical sensor pulses or logic probes. It logs when each one changes level. Every input first passes through a synchronizer. A free-running timestamp counter advances once per clock. In any clock where at least one synchronized level differs from its value on the previous clock, the block forms one record. The record holds the counter value and the present levels of all channels, and the block pushes it into an on-chip FIFO.

Quiet inputs produce nothing, so the recorder also writes a record each time the counter rolls over from its top value to zero. Software reading the records can count these rollovers to rebuild a timestamp of any width. The FIFO absorbs bursts of edges while the reader lags and drains during quiet stretches. When the FIFO is full, a new record is dropped and a sticky overflow flag is raised. A build option stores the timestamp as Gray code instead of binary.

The reader sees the oldest record on a show-ahead port with a valid flag, and a read strobe removes it.

Top module: `trans_stamp_recorder`

## Requirements
- R1: After reset `rd_valid` and `ovf_flag` are low and the timestamp counter is zero; it becomes 1 on the first clock edge with `rst_n` high.
- R2: The counter advances by one on every clock edge, modulo 2^TS_W. Suppose a new input pattern is applied just after edge k and held. Its record is written on edge k+3 and visible after it. The stamp equals the counter value between edges k+2 and k+3, which is the number of edges since reset release up to edge k+2, modulo 2^TS_W.
- R3: A record is TS_W+CH_N bits wide. Bits [TS_W+CH_N-1:CH_N] hold the stamp and bits [CH_N-1:0] hold the synchronized channel levels, with channel i at bit i.
- R4: Exactly one record is written per clock in which one or more synchronized levels changed, however many changed. No record is written while all levels stay the same.
- R5: When the counter goes from all ones to zero, a record is written on the next edge with stamp 0 and the current levels, even with no input change.
- R6: A level change and a rollover that fall in the same clock produce a single record, and that record carries stamp 0.
- R7: Records leave in the order written. `rd_valid` is high whenever at least one is stored, `rd_data` shows the oldest, and `rd_en` with `rd_valid` high removes it on the clock edge.
- R8: `rd_en` while `rd_valid` is low has no effect; the FIFO stays empty.
- R9: A record arriving while the FIFO holds DEPTH records and no read is removing one is discarded. The stored records are unchanged, and `ovf_flag` goes high and stays high until `ovf_clr` is pulsed; a new drop in the same cycle wins over the clear.
- R10: With TS_CODE set to Gray, the stamp field is b ^ (b >> 1), where b is the binary stamp that R2 defines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_in | input | CH_N | Asynchronous channel levels |
| rd_en | input | 1 | Remove the head record |
| rd_valid | output | 1 | A record is available |
| rd_data | output | TS_W+CH_N | Oldest stored record |
| ovf_flag | output | 1 | Sticky record-drop flag |
| ovf_clr | input | 1 | Clear the overflow flag |

## Verification
A change on `chan_in` passes two synchronizer flops and is written on the third edge, so the bench drives patterns just after a falling edge. It then inspects the port three falling edges later, and the stamp it expects is its own edge count two edges after the drive. Rollover records appear on the edge after the counter hits zero, which the bench predicts from its edge count since reset. It places one input change so that it lands exactly on that edge. A pop takes effect on the next edge and is checked at the following falling edge. The overflow flag is read only after the last dropped write has had its edge.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   // Encoding of the timestamp field carried in each record.
   typedef enum logic {
      TS_BINARY = 1'b0,
      TS_GRAY   = 1'b1
   } ts_code_e;

   // Flip-flops on each input ahead of change detection.
   localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
   parameter int unsigned CH_N   = 16,
   parameter int unsigned STAGES = tsr_pkg::SYNC_STAGES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_N-1:0] async_in,
   output logic [CH_N-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tsr_sync: STAGES must be at least 2");
      end
   endgenerate

   // One flop chain per channel.
   generate
      for (genvar c = 0; c < CH_N; c++) begin : g_chan
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], async_in[c]};
            end
         end
         assign sync_out[c] = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tsr_detect.sv
module tsr_detect #(
   parameter int unsigned CH_N = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_N-1:0] lvl,
   output logic            changed
);
   logic [CH_N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= lvl;
      end
   end

   assign changed = |(lvl ^ prev_q);
endmodule

// File: rtl/tsr_stamp.sv
module tsr_stamp #(
   parameter int unsigned       TS_W    = 16,
   parameter tsr_pkg::ts_code_e TS_CODE = tsr_pkg::TS_BINARY
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] ts_field,
   output logic            wrap_evt
);
   localparam logic [TS_W-1:0] TS_MAX = '1;

   logic [TS_W-1:0] cnt_q;
   logic            wrap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         wrap_q <= (cnt_q == TS_MAX);
      end
   end

   assign wrap_evt = wrap_q;

   generate
      if (TS_CODE == tsr_pkg::TS_GRAY) begin : g_gray
         assign ts_field = cnt_q ^ (cnt_q >> 1);
      end else begin : g_binary
         assign ts_field = cnt_q;
      end
   endgenerate

   // R2: counter steps by one below its top value
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != TS_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R5: rollover lands on zero and raises the wrap event
   assert_rollover_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == TS_MAX) |=> (wrap_q && cnt_q == '0));

   // R5: wrap event lasts a single clock
   assert_wrap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |=> !wrap_q);
endmodule

// File: rtl/tsr_fifo.sv
module tsr_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 512
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         rd_en,
   output logic         rd_valid,
   output logic [W-1:0] rd_data,
   input  logic         ovf_clr,
   output logic         ovf_flag
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;
   logic          ovf_q;
   logic          full, pop, accept, drop;

   assign full   = (cnt_q == FULL_CNT);
   assign pop    = rd_en && (cnt_q != '0);
   assign accept = push && (!full || pop);
   assign drop   = push && full && !pop;

   always_ff @(posedge clk) begin
      if (accept) begin
         mem_q[tail_q] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (accept) begin
            tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
         end
         if (pop) begin
            head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
         end
         case ({accept, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (drop) begin
            ovf_q <= 1'b1;
         end else if (ovf_clr) begin
            ovf_q <= 1'b0;
         end
      end
   end

   assign rd_valid = (cnt_q != '0);
   assign rd_data  = mem_q[head_q];
   assign ovf_flag = ovf_q;

   // R7: a pushed record leaves the FIFO non-empty
   assert_valid_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> rd_valid);

   // R8: a read of an empty FIFO leaves it empty
   assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_valid && !push) |=> !rd_valid);

   // R9: a drop keeps the occupancy and the head record
   assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !rd_en) |=> ($stable(cnt_q) && $stable(rd_data)));

   // R9: a drop raises the flag
   assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !rd_en) |=> ovf_flag);

   // R9: the flag holds until cleared
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/trans_stamp_recorder.sv
module trans_stamp_recorder #(
   parameter int unsigned       CH_N    = 16,
   parameter int unsigned       TS_W    = 16,
   parameter int unsigned       DEPTH   = 512,
   parameter tsr_pkg::ts_code_e TS_CODE = tsr_pkg::TS_BINARY,
   localparam int unsigned      REC_W   = TS_W + CH_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CH_N-1:0]  chan_in,
   input  logic             rd_en,
   output logic             rd_valid,
   output logic [REC_W-1:0] rd_data,
   output logic             ovf_flag,
   input  logic             ovf_clr
);
   generate
      if (CH_N < 1) begin : g_bad_ch
         $error("trans_stamp_recorder: CH_N must be at least 1");
      end
      if (TS_W < 2) begin : g_bad_ts
         $error("trans_stamp_recorder: TS_W must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("trans_stamp_recorder: DEPTH must be at least 2");
      end
   endgenerate

   logic [CH_N-1:0]  lvl;
   logic             changed;
   logic [TS_W-1:0]  ts_field;
   logic             wrap_evt;
   logic             push;
   logic [REC_W-1:0] record;

   tsr_sync #(.CH_N(CH_N)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (chan_in),
      .sync_out (lvl)
   );

   tsr_detect #(.CH_N(CH_N)) detect_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .changed (changed)
   );

   tsr_stamp #(.TS_W(TS_W), .TS_CODE(TS_CODE)) stamp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ts_field (ts_field),
      .wrap_evt (wrap_evt)
   );

   // One record per clock covers a change, a rollover or both.
   assign push   = changed || wrap_evt;
   assign record = {ts_field, lvl};

   tsr_fifo #(.W(REC_W), .DEPTH(DEPTH)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (record),
      .rd_en     (rd_en),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .ovf_clr   (ovf_clr),
      .ovf_flag  (ovf_flag)
   );

   // R5/R6: a rollover record always carries stamp zero
   assert_wrap_stamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |-> (ts_field == '0));
endmodule

// File: tb/trans_stamp_recorder_tb_top.sv
module trans_stamp_recorder_tb_top;
   localparam int unsigned CH = 4;
   localparam int unsigned TW = 8;
   localparam int unsigned DP = 8;
   localparam int unsigned RW = TW + CH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CH-1:0] chan_in = '0;
   logic          rd_en = 1'b0;
   logic          ovf_clr = 1'b0;
   logic          rd_valid, rd_valid_g, ovf_flag, ovf_flag_g;
   logic [RW-1:0] rd_data, rd_data_g;

   int checks = 0;
   int errors = 0;
   int bcyc;
   bit done = 1'b0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) bcyc <= 0;
      else        bcyc <= bcyc + 1;
   end

   trans_stamp_recorder #(.CH_N(CH), .TS_W(TW), .DEPTH(DP),
                          .TS_CODE(tsr_pkg::TS_BINARY)) dut_i (
      .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .rd_en(rd_en),
      .rd_valid(rd_valid), .rd_data(rd_data), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr));

   trans_stamp_recorder #(.CH_N(CH), .TS_W(TW), .DEPTH(DP),
                          .TS_CODE(tsr_pkg::TS_GRAY)) dutg_i (
      .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .rd_en(rd_en),
      .rd_valid(rd_valid_g), .rd_data(rd_data_g), .ovf_flag(ovf_flag_g), .ovf_clr(ovf_clr));

   localparam logic [CH-1:0] PAT [8] = '{4'h1, 4'h3, 4'hF, 4'hE, 4'h0, 4'hA, 4'h5, 4'h8};

   function automatic logic [TW-1:0] gray(input logic [TW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // Expect one head record on both instances, then pop it.
   task automatic expect_rec(input string req, input logic [TW-1:0] st, input logic [CH-1:0] lv);
      chk({req, " valid"}, 32'(rd_valid), 32'd1);
      chk({req, " record"}, 32'(rd_data), 32'({st, lv}));
      chk({req, " gray R10"}, 32'(rd_data_g), 32'({gray(st), lv}));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
   end

   initial begin
      int t0;
      logic [CH-1:0] cur;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);
      chk("R1 ovf_flag", 32'(ovf_flag), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R7: table of patterns, one record each
      for (int i = 0; i < 8; i++) begin
         chan_in = PAT[i];
         t0 = bcyc;
         repeat (3) @(negedge clk);
         expect_rec("R2 R3 R4 table", TW'(t0 + 2), PAT[i]);
         chk("R7 drained", 32'(rd_valid), 32'd0);
      end
      cur = PAT[7];

      // R4: re-driving the same levels writes nothing
      chan_in = cur;
      repeat (4) @(negedge clk);
      chk("R4 no change", 32'(rd_valid), 32'd0);

      // R8: read while empty, then a fresh record still reads correctly
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R8 empty read", 32'(rd_valid), 32'd0);
      cur = 4'h7;
      chan_in = cur;
      t0 = bcyc;
      repeat (3) @(negedge clk);
      expect_rec("R8 after empty read", TW'(t0 + 2), cur);
      chk("R8 drained", 32'(rd_valid), 32'd0);

      // R7: two records come out oldest first
      cur = 4'h2;
      chan_in = cur;
      t0 = bcyc;
      @(negedge clk);
      chan_in = 4'h4;
      repeat (3) @(negedge clk);
      expect_rec("R7 first", TW'(t0 + 2), 4'h2);
      expect_rec("R7 second", TW'(t0 + 3), 4'h4);
      chk("R7 drained", 32'(rd_valid), 32'd0);
      cur = 4'h4;

      // R5: rollover record with stamp zero
      while (bcyc != 256) @(negedge clk);
      chk("R5 before wrap", 32'(rd_valid), 32'd0);
      @(negedge clk);
      expect_rec("R5 wrap", '0, cur);
      chk("R5 single", 32'(rd_valid), 32'd0);

      // R6: change landing on the rollover edge gives one record
      while (bcyc != 510) @(negedge clk);
      cur = 4'hB;
      chan_in = cur;
      repeat (3) @(negedge clk);
      expect_rec("R6 merged", '0, cur);
      chk("R6 single record", 32'(rd_valid), 32'd0);

      // R9: ten writes into an eight-entry FIFO
      while (bcyc != 520) @(negedge clk);
      for (int j = 0; j < 10; j++) begin
         chan_in = (j % 2 == 0) ? ~cur : cur;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
      chk("R9 flag set", 32'(ovf_flag), 32'd1);
      chk("R9 flag set gray", 32'(ovf_flag_g), 32'd1);
      for (int j = 0; j < 8; j++) begin
         expect_rec("R9 kept", TW'(10 + j), (j % 2 == 0) ? ~cur : cur);
      end
      chk("R9 extras dropped", 32'(rd_valid), 32'd0);
      chk("R9 sticky", 32'(ovf_flag), 32'd1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      chk("R9 cleared", 32'(ovf_flag), 32'd0);

      summary();
   end
endmodule